// File: doc/BRIEF.md
# Multi-Channel Input Capture Unit

This block timestamps signal transitions on three external capture pins. Each pin is brought into the clock domain through a two-flop synchronizer. When an enabled edge is seen, the block stores the value of one of two free-running timer inputs into a two-entry result queue for that channel. A small register port gives software the following:

- per-channel edge choice, channel enables and timer choice;
- a status word that shows how many timestamps are waiting in each queue;
- interrupt flags and masks;
- a command bit that empties every queue.

Software can take an interrupt on each capture. It can also leave the interrupt masked and poll the flags and the queue status. This lets it wait until both edges of a pulse have been stored and then read the two timestamps to get the pulse width. The third channel can also emit a one-cycle analog-converter start pulse each time it captures.

Each channel queue is a state machine with four states. The state value is also the status code:

| State | Code | Meaning |
|---|---|---|
| Q_EMPTY | 00 | no entry |
| Q_ONE | 01 | one entry |
| Q_TWO | 10 | two entries |
| Q_OVF | 11 | two entries held; at least one older entry was dropped |

The transitions are:

- **push**: Q_EMPTY→Q_ONE, Q_ONE→Q_TWO, Q_TWO→Q_OVF, Q_OVF→Q_OVF. In the last two, the oldest entry is dropped.
- **pop** (a result read): Q_ONE→Q_EMPTY, Q_TWO→Q_ONE, Q_OVF→Q_ONE.
- **push with pop in the same cycle**: Q_ONE and Q_TWO keep their state. Q_OVF goes to Q_TWO.
- **clear**: any state→Q_EMPTY. Clear takes priority over push and pop.

Top module: `cap_unit`

## Requirements
- R1: The control word (address 0) holds a two-bit edge field for channel c (0..2) at bits [2c+1:2c]. Code 00 captures nothing, 01 captures rising edges only, 10 captures falling edges only, and 11 captures both.
- R2: Channels 0 and 1 capture only when the pair mode field (control bits [7:6]) is 01. Codes 00, 10 and 11 stop all captures on both channels.
- R3: Channel 2 captures only when its enable bit (control bit 8) is 1.
- R4: A captured value comes from `timer_first` when the timer-select bit is 1, and from `timer_second` when it is 0. Control bit 9 selects the timer for channels 0 and 1. Control bit 10 selects it for channel 2.
- R5: Each queue holds two entries. The status word (address 1) shows channel c's code at bits [2c+1:2c]: 00 empty, 01 one, 10 two, 11 overflow. On a capture into a full queue, the oldest entry is dropped and the newest is kept.
- R6: Reading the result register of channel c (address 4+c) returns the oldest entry, zero-extended, and removes it from the queue. Reading an empty queue returns 0 and changes nothing.
- R7: Every capture sets the channel's flag (address 2, bit c). Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A capture in the same cycle as a clear leaves the flag set.
- R8: `irq` is high while any flag is set whose mask bit (address 3, bit c) is 1. A masked flag still reads as set.
- R9: Writing the control word with bit 15 at 0 empties every queue. Writing it with bit 15 at 1 leaves the queues unchanged. Bit 15 is not stored and reads as 1. After reset, the control word reads 0x8000.
- R10: When control bit 11 is 1, each channel-2 capture gives exactly one high cycle on `adc_soc`. When bit 11 is 0, no pulse is issued.
- R11: A pin transition that is stable at a clock edge sets the flag and stores the timer value at the third rising edge after that transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 3 | Asynchronous capture pins, bit c is channel c |
| timer_first | input | TW | First free-running timer count |
| timer_second | input | TW | Second free-running timer count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a result read also pops that queue |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Masked OR of the capture flags |
| adc_soc | output | 1 | One-cycle analog-converter start pulse |

## Verification
A queue state machine in the wrong state shows at the ports within one register read, in one of two ways:

- the status code at address 1 is wrong;
- a result read returns the wrong entry, or a stale entry where 0 was due.

A wrong flag or mask shows on `irq` in the cycle after the capture. A missing or doubled pulse on `adc_soc` shows within the three-cycle synchronizer window of the capture. Corrupted storage after an overflow shows up only when the second-oldest entry is popped, so every overflow in the bench is drained and each entry compared.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int NCH      = 3;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd3;
    localparam int                A_RES0 = 4;

    localparam logic [1:0] PAIR_CAPTURE = 2'b01;
    localparam int         CLR_BIT      = 15;

    // State code doubles as the software-visible status code
    typedef enum logic [1:0] {
        Q_EMPTY = 2'b00,
        Q_ONE   = 2'b01,
        Q_TWO   = 2'b10,
        Q_OVF   = 2'b11
    } qstate_e;

endpackage

// File: rtl/cap_edge.sv
module cap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign rise =  chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] &  chain[STAGES];

    // R1
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/cap_fifo.sv
module cap_fifo
    import cap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output qstate_e      st,
    output logic [W-1:0] head
);

    qstate_e      st_q, st_d;
    logic [W-1:0] e0, e1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= Q_EMPTY;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = Q_EMPTY;
        end else begin
            unique case (st_q)
                Q_EMPTY: if (push) st_d = Q_ONE;
                Q_ONE: begin
                    if (push && !pop)      st_d = Q_TWO;
                    else if (!push && pop) st_d = Q_EMPTY;
                end
                Q_TWO: begin
                    if (push && !pop)      st_d = Q_OVF;
                    else if (!push && pop) st_d = Q_ONE;
                end
                Q_OVF: begin
                    if (push && pop)       st_d = Q_TWO;
                    else if (pop)          st_d = Q_ONE;
                end
                default: st_d = Q_EMPTY;
            endcase
        end
    end

    // Entry storage, e0 is always the oldest
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e0 <= '0;
            e1 <= '0;
        end else if (!clr) begin
            case (st_q)
                Q_EMPTY: if (push) e0 <= din;
                Q_ONE: begin
                    if (push && pop) e0 <= din;
                    else if (push)   e1 <= din;
                end
                default: begin
                    if (push) begin
                        e0 <= e1;
                        e1 <= din;
                    end else if (pop) begin
                        e0 <= e1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        st   = st_q;
        head = (st_q == Q_EMPTY) ? '0 : e0;
    end

    // R5
    ovf_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_TWO && push && !pop && !clr) |=> (st_q == Q_OVF));

    // R9
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == Q_EMPTY));

    // R6
    pop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_ONE && pop && !push && !clr) |=> (st_q == Q_EMPTY));

endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int TW   = 16,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cap_pin,
    input  logic [TW-1:0]     timer_first,
    input  logic [TW-1:0]     timer_second,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              adc_soc
);

    logic [NCH-1:0][1:0] edge_sel;
    logic [1:0]          pair_mode;
    logic                solo_en, pair_tsel, solo_tsel, adc_en;
    logic [NCH-1:0]      flags, mask;

    logic [NCH-1:0]         rise, fall, chan_on, tsel, capture, pop;
    logic [NCH-1:0][TW-1:0] tval, head;
    qstate_e                qst [NCH];

    logic wr_ctrl, wr_flag, wr_mask, fifo_clr;
    logic unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
    assign wr_flag      = reg_wr && (reg_addr == A_FLAG);
    assign wr_mask      = reg_wr && (reg_addr == A_MASK);
    assign fifo_clr     = wr_ctrl && !reg_wdata[CLR_BIT];
    assign unused_wbits = ^reg_wdata[14:12];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_sel  <= '0;
            pair_mode <= '0;
            solo_en   <= 1'b0;
            pair_tsel <= 1'b0;
            solo_tsel <= 1'b0;
            adc_en    <= 1'b0;
            mask      <= '0;
        end else begin
            if (wr_ctrl) begin
                edge_sel  <= reg_wdata[5:0];
                pair_mode <= reg_wdata[7:6];
                solo_en   <= reg_wdata[8];
                pair_tsel <= reg_wdata[9];
                solo_tsel <= reg_wdata[10];
                adc_en    <= reg_wdata[11];
            end
            if (wr_mask) mask <= reg_wdata[NCH-1:0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            localparam logic [ADDR_W-1:0] RES_ADDR = ADDR_W'(A_RES0 + g);

            cap_edge #(.STAGES(SYNC)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (cap_pin[g]),
                .rise (rise[g]),
                .fall (fall[g])
            );

            if (g < NCH - 1) begin : g_pair
                assign chan_on[g] = (pair_mode == PAIR_CAPTURE);
                assign tsel[g]    = pair_tsel;
            end else begin : g_solo
                assign chan_on[g] = solo_en;
                assign tsel[g]    = solo_tsel;
            end

            assign capture[g] = chan_on[g] &
                ((edge_sel[g][0] & rise[g]) | (edge_sel[g][1] & fall[g]));
            assign tval[g]    = tsel[g] ? timer_first : timer_second;
            assign pop[g]     = reg_rd && (reg_addr == RES_ADDR);

            cap_fifo #(.W(TW)) u_fifo (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (fifo_clr),
                .push (capture[g]),
                .pop  (pop[g]),
                .din  (tval[g]),
                .st   (qst[g]),
                .head (head[g])
            );

            // R7
            flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                capture[g] |=> flags[g]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            adc_soc <= 1'b0;
        end else begin
            flags   <= (flags & ~(wr_flag ? reg_wdata[NCH-1:0] : '0)) | capture;
            adc_soc <= capture[NCH-1] & adc_en;
        end
    end

    assign irq = |(flags & mask);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = {1'b1, 3'b000, adc_en, solo_tsel, pair_tsel,
                                 solo_en, pair_mode, edge_sel};
            A_STAT: for (int i = 0; i < NCH; i++) reg_rdata[2*i +: 2] = qst[i];
            A_FLAG: reg_rdata[NCH-1:0] = flags;
            A_MASK: reg_rdata[NCH-1:0] = mask;
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (reg_addr == ADDR_W'(A_RES0 + i)) reg_rdata[TW-1:0] = head[i];
            end
        endcase
    end

    // R10
    adc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_soc |-> flags[NCH-1]);

    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

endmodule

// File: tb/sim_cap_unit.sv
module sim_cap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cap_pin = '0;
    logic [15:0] t1 = '0, t2 = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    wire  [15:0] reg_rdata;
    wire         irq, adc_soc;

    cap_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin),
        .timer_first(t1), .timer_second(t2),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .adc_soc(adc_soc)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model
    logic [1:0]  medge [3];
    logic [1:0]  mpair = 0;
    logic        men3 = 0, mptsel = 0, m3tsel = 0, madc = 0;
    logic [2:0]  mflags = 0, mmask = 0;
    logic [15:0] mq0 [3], mq1 [3];
    int          mcnt [3];

    function automatic logic [15:0] ctrl_word();
        return {1'b1, 3'b000, madc, m3tsel, mptsel, men3, mpair, medge[2], medge[1], medge[0]};
    endfunction

    function automatic bit is_cap(int ch, logic rising);
        bit on = (ch == 2) ? men3 : (mpair == 2'b01);
        return on && (rising ? medge[ch][0] : medge[ch][1]);
    endfunction

    function automatic void m_push(int ch, logic [15:0] v);
        if (mcnt[ch] == 0) begin mq0[ch] = v; mcnt[ch] = 1; end
        else if (mcnt[ch] == 1) begin mq1[ch] = v; mcnt[ch] = 2; end
        else begin mq0[ch] = mq1[ch]; mq1[ch] = v; mcnt[ch] = 3; end
    endfunction

    function automatic logic [15:0] m_pop(int ch);
        logic [15:0] v;
        if (mcnt[ch] == 0) return 16'h0;
        v = mq0[ch];
        if (mcnt[ch] == 1) mcnt[ch] = 0;
        else begin mq0[ch] = mq1[ch]; mcnt[ch] = 1; end
        return v;
    endfunction

    function automatic logic [15:0] m_status();
        return {10'b0, 2'(mcnt[2]), 2'(mcnt[1]), 2'(mcnt[0])};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_ctrl(logic [15:0] w);
        wr_reg(3'd0, w);
        medge[0] = w[1:0]; medge[1] = w[3:2]; medge[2] = w[5:4];
        mpair = w[7:6]; men3 = w[8]; mptsel = w[9]; m3tsel = w[10]; madc = w[11];
        if (!w[15]) for (int c = 0; c < 3; c++) mcnt[c] = 0;
    endtask

    task automatic set_mask(logic [2:0] m);
        wr_reg(3'd3, {13'b0, m});
        mmask = m;
    endtask

    task automatic clr_flags(logic [2:0] m);
        wr_reg(3'd2, {13'b0, m});
        mflags = mflags & ~m;
    endtask

    task automatic check_state();
        logic [15:0] d;
        rd_reg(3'd1, d);
        chk("R5 status", d, m_status());
        rd_reg(3'd2, d);
        chk("R7 flags", d, {13'b0, mflags});
        chk("R8 irq", irq, |(mflags & mmask));
    endtask

    task automatic pop_chk(int ch);
        logic [15:0] d;
        logic [15:0] e;
        rd_reg(3'(4 + ch), d);
        e = m_pop(ch);
        chk("R6 result", d, e);
    endtask

    // R11: flag and entry appear at the third rising edge after the pin change
    task automatic toggle(int ch, logic [15:0] a, logic [15:0] b);
        int p = 0;
        logic lvl;
        bit cap;
        lvl = ~cap_pin[ch];
        @(negedge clk);
        t1 = a; t2 = b; cap_pin[ch] = lvl;
        repeat (5) begin
            @(negedge clk);
            if (adc_soc) p++;
        end
        cap = is_cap(ch, lvl);
        if (cap) begin
            m_push(ch, ((ch == 2) ? m3tsel : mptsel) ? a : b);
            mflags[ch] = 1'b1;
        end
        chk("R10 adc pulses", p, (ch == 2 && cap && madc) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 act=timeout exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5eed_0c1a));
        for (int c = 0; c < 3; c++) begin medge[c] = 0; mcnt[c] = 0; mq0[c] = 0; mq1[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd_reg(3'd0, d);
        chk("R9 ctrl reset", d, 16'h8000);
        chk("R10 adc idle", adc_soc, 0);
        check_state();

        // ch0 rising, ch1 falling, ch2 both; pair on, ch2 on, pair timer first, ch2 timer second, adc on
        set_ctrl(16'h8B79);
        rd_reg(3'd0, d);
        chk("R9 ctrl readback", d, 16'h8B79);

        toggle(0, 16'h1111, 16'h2222);            // R1 rising captured, R4 first timer
        check_state();
        toggle(0, 16'hAAAA, 16'hBBBB);            // R1 falling ignored
        check_state();
        toggle(0, 16'h3333, 16'h0);
        toggle(0, 16'h0, 16'h0);
        toggle(0, 16'h5555, 16'h0);               // third entry: overflow
        check_state();                            // R5 code 11
        pop_chk(0); pop_chk(0); pop_chk(0);       // R6 expect 3333, 5555, then 0
        check_state();

        toggle(1, 16'h0101, 16'h0);               // R1 rising ignored on falling-only
        toggle(1, 16'h0202, 16'h0);               // captured
        check_state();
        pop_chk(1);

        toggle(2, 16'h1234, 16'hBEEF);            // R4 second timer, R10 pulse
        toggle(2, 16'h1234, 16'hCAFE);            // R1 both edges
        check_state();
        pop_chk(2); pop_chk(2);

        // R2: pair modes 00, 10, 11 stop captures
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            set_ctrl({8'h8B, 2'(m), 6'h3F});
            toggle(0, 16'h7, 16'h7); toggle(0, 16'h8, 16'h8);
            toggle(1, 16'h9, 16'h9); toggle(1, 16'hA, 16'hA);
            check_state();
        end

        // R3: ch2 disabled
        set_ctrl(16'h8A7F);
        toggle(2, 16'hD00D, 16'hD00D);
        toggle(2, 16'hD00E, 16'hD00E);
        check_state();

        // R8: mask gating; R7 write-1-to-clear
        set_mask(3'b000);
        check_state();
        set_mask(3'b010);
        check_state();
        set_mask(3'b011);
        check_state();
        clr_flags(3'b001);
        check_state();
        clr_flags(3'b111);
        check_state();

        // R9: bit15 = 1 keeps queues, bit15 = 0 empties them
        set_ctrl(16'h8B7F);
        toggle(0, 16'h4444, 16'h0);
        toggle(0, 16'h4445, 16'h0);
        set_ctrl(16'h8B7F);
        check_state();
        set_ctrl(16'h0B7F);
        rd_reg(3'd0, d);
        chk("R9 bit15 reads one", d, 16'h8B7F);
        check_state();
        pop_chk(0);

        // R7: capture coincident with clear keeps the flag
        set_ctrl(16'h8B79);
        if (cap_pin[0]) toggle(0, 16'h0, 16'h0);
        @(negedge clk);
        t1 = 16'h7777; cap_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0001;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        m_push(0, 16'h7777);
        mflags[0] = 1'b1;
        check_state();
        clr_flags(3'b001);
        check_state();
        pop_chk(0);

        // R10: no pulse when the start bit is clear
        set_ctrl(16'h8779);
        toggle(2, 16'h1, 16'h2);
        toggle(2, 16'h3, 16'h4);
        check_state();

        // Random phase
        for (int it = 0; it < 500; it++) begin
            int op = $urandom_range(0, 9);
            if (op <= 5) begin
                toggle($urandom_range(0, 2), 16'($urandom), 16'($urandom));
            end else if (op == 6) begin
                pop_chk($urandom_range(0, 2));
            end else if (op == 7) begin
                logic [15:0] w = 16'($urandom);
                w[14:12] = 3'b000;
                if ($urandom_range(0, 7) != 0) w[15] = 1'b1;
                else w[15] = 1'b0;
                if ($urandom_range(0, 2) != 0) w[7:6] = 2'b01;
                set_ctrl(w);
            end else if (op == 8) begin
                clr_flags(3'($urandom));
            end else begin
                set_mask(3'($urandom));
            end
            if (it % 4 == 0) check_state();
        end
        check_state();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule